// File: doc/BRIEF.md
# Packet-Triggered Processing Element

This block is one compute node of a reactive coarse-grained array. It has no program counter and no local sequencer: it does work only in the cycle a packet is accepted on its input. A packet is a single beat of a 4-bit packet ID and a 32-bit value. For ordinary IDs, the ID indexes a small local action table. The selected entry names an ALU function, how the second operand is obtained, which register-file writes take place, the ID carried by the resulting packet, and the direction it leaves in, or that it is consumed with no output.

Two reserved IDs skip the table and carry their own target coordinates in the value. ID 0 writes one action entry, and ID 1 loads a 16-bit constant into one of 32 registers. A node that is not the addressed target passes a reserved packet on unchanged: east while the column differs, otherwise south. This lets a configuration stream that enters at one corner reach every node. The result leaves through one output register with a valid/ready handshake. Input ready drops while that register is full and stalled, so nothing is ever lost.

Top module: `pkt_pe`

## Requirements
- R1: The output holds its ID, value and direction stable while `out_valid` is high and `out_ready` is low. In that state `in_ready` is low. When `out_ready` rises, a waiting input is accepted in the same cycle that the held output is taken.
- R2: After reset no output is pending. Every action entry consumes its packet without any write or output, and all 32 registers read as zero.
- R3: An ID 0 packet whose value bits [30:27] equal the node's {row[1:0], col[1:0]} writes value bits [22:0] into the action entry indexed by bits [26:23]. It emits nothing.
- R4: An ID 1 packet whose bits [30:27] address this node writes the zero-extended bits [15:0] into the register indexed by bits [20:16]. It emits nothing.
- R5: An ID 0 or ID 1 packet addressed to another node is re-emitted with the same ID and value one cycle after acceptance. Its direction is east (1) when target bits [28:27] differ from the node's column, otherwise south (2). No table or register state changes.
- R6: An action entry is laid out, from bit 22 down to bit 0, as response ID [22:19], destination [18:16], source register [15:11], destination register [10:6], result-write enable [5], immediate-write enable [4], source-is-immediate [3] and function [2:0].
- R7: The function codes are 0 add, 1 shift left, 2 arithmetic shift right, 3 subtract (a−b), 4 XOR, 5 pass b, 6 OR and 7 AND. Shifts use only the low 5 bits of b.
- R8: Operand a is the packet value. Operand b is the register named by the source field, or the zero-extended source field itself when source-is-immediate is set.
- R9: Result-write enable stores the ALU result in the destination register, and immediate-write enable stores the packet value there instead. Immediate-write takes precedence when both are set.
- R10: Destination codes 0 to 3 emit a packet with the entry's response ID and the ALU result, with out_dir 0 north, 1 east, 2 south, 3 west. Codes 4 to 7 emit nothing but still perform the entry's register write.
- R11: In a cycle with no accepted packet, no table entry or register changes and no new output appears, whatever the values on the input ID and data lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input packet present |
| in_ready | output | 1 | Node can take a packet this cycle |
| in_id | input | 4 | Incoming packet ID |
| in_data | input | 32 | Incoming packet value |
| out_valid | output | 1 | Output packet present |
| out_ready | input | 1 | Downstream takes the output packet |
| out_id | output | 4 | Outgoing packet ID |
| out_data | output | 32 | Outgoing packet value |
| out_dir | output | 2 | Outgoing direction: 0 north, 1 east, 2 south, 3 west |

## Verification
The ALU is swept over all eight function codes against a grid of eight register operands and eight packet operands. The operands include zero, all ones, the sign bit alone, shift amounts of 31 and of 35 (where only the low five bits must count), and mixed-bit words, so carries, sign fill and truncated shift counts are each told apart. Every target coordinate other than the node's own is sent with both reserved IDs. This separates the east and south forwarding rules and confirms that no foreign packet alters the table or registers. Each of the 32 registers is loaded and read back, and all eight destination codes are tried. These patterns expose a wrong register index, a wrong sink decode, and a lost side effect on a silent action. A held-output stall and an idle stretch with live-looking data on the input lines check the handshake and the purely reactive behaviour.

// File: rtl/pe_pkg.sv
package pe_pkg;

  localparam int PID_W   = 4;
  localparam int DATA_W  = 32;
  localparam int NREGS   = 32;
  localparam int RIDX_W  = $clog2(NREGS);
  localparam int NACTS   = 1 << PID_W;
  localparam int POS_W   = 2;
  localparam int DIR_W   = 2;

  // Field positions inside the value of reserved packets
  localparam int TGT_LO  = 27;
  localparam int TGT_HI  = TGT_LO + 2 * POS_W - 1;
  localparam int SLOT_LO = 23;
  localparam int SLOT_HI = SLOT_LO + PID_W - 1;
  localparam int CREG_LO = 16;
  localparam int CREG_HI = CREG_LO + RIDX_W - 1;
  localparam int CVAL_W  = 16;

  localparam logic [PID_W-1:0] PID_SETACT = 4'd0;
  localparam logic [PID_W-1:0] PID_SETREG = 4'd1;

  typedef enum logic [2:0] {
    FN_ADD   = 3'd0,
    FN_SHL   = 3'd1,
    FN_SRA   = 3'd2,
    FN_SUB   = 3'd3,
    FN_XOR   = 3'd4,
    FN_PASSB = 3'd5,
    FN_OR    = 3'd6,
    FN_AND   = 3'd7
  } pe_fn_e;

  localparam logic [2:0]       DEST_SINK = 3'd4;
  localparam logic [DIR_W-1:0] DIR_EAST  = 2'd1;
  localparam logic [DIR_W-1:0] DIR_SOUTH = 2'd2;

  typedef struct packed {
    logic [PID_W-1:0]  resp_id;
    logic [2:0]        dest;
    logic [RIDX_W-1:0] src;
    logic [RIDX_W-1:0] rd;
    logic              res_we;
    logic              val_we;
    logic              src_is_imm;
    logic [2:0]        fn;
  } pe_action_t;

  localparam int ACT_W = $bits(pe_action_t);

  localparam pe_action_t ACT_IDLE = '{
    resp_id:    '0,
    dest:       DEST_SINK,
    src:        '0,
    rd:         '0,
    res_we:     1'b0,
    val_we:     1'b0,
    src_is_imm: 1'b0,
    fn:         3'd0
  };

endpackage

// File: rtl/pe_action_table.sv
module pe_action_table
  import pe_pkg::*;
#(
  parameter int DEPTH = NACTS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  pe_action_t               wr_act,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output pe_action_t               rd_act
);

  localparam int IW = $clog2(DEPTH);

  pe_action_t slots [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic       sel;
    pe_action_t q;
    assign sel = wr_en && (wr_idx == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= ACT_IDLE;
      end else if (sel) begin
        q <= wr_act;
      end
    end

    assign slots[g] = q;
  end

  assign rd_act = slots[rd_idx];

endmodule

// File: rtl/pe_regfile.sv
module pe_regfile
  import pe_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int DEPTH = NREGS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [DW-1:0]            wr_val,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [DW-1:0]            rd_val
);

  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] regs [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    logic          sel;
    logic [DW-1:0] q;
    assign sel = wr_en && (wr_idx == AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (sel) begin
        q <= wr_val;
      end
    end

    assign regs[g] = q;
  end

  assign rd_val = regs[rd_idx];

endmodule

// File: rtl/pe_alu.sv
module pe_alu
  import pe_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [2:0]    fn,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic [DW-1:0] res
);

  localparam int SH_W = $clog2(DW);

  logic [SH_W-1:0] shamt;
  assign shamt = opb[SH_W-1:0];

  always_comb begin
    unique case (pe_fn_e'(fn))
      FN_ADD:   res = opa + opb;
      FN_SHL:   res = opa << shamt;
      FN_SRA:   res = DW'($signed(opa) >>> shamt);
      FN_SUB:   res = opa - opb;
      FN_XOR:   res = opa ^ opb;
      FN_PASSB: res = opb;
      FN_OR:    res = opa | opb;
      FN_AND:   res = opa & opb;
      default:  res = '0;
    endcase
  end

endmodule

// File: rtl/pe_out_stage.sv
module pe_out_stage
  import pe_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int IDW = PID_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDW-1:0]   ld_id,
  input  logic [DW-1:0]    ld_data,
  input  logic [DIR_W-1:0] ld_dir,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [IDW-1:0]   out_id,
  output logic [DW-1:0]    out_data,
  output logic [DIR_W-1:0] out_dir
);

  logic valid_d;

  always_comb begin
    valid_d = out_valid;
    if (load) begin
      valid_d = 1'b1;
    end else if (out_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_id   <= '0;
      out_data <= '0;
      out_dir  <= '0;
    end else if (load) begin
      out_id   <= ld_id;
      out_data <= ld_data;
      out_dir  <= ld_dir;
    end
  end

endmodule

// File: rtl/pkt_pe.sv
module pkt_pe
  import pe_pkg::*;
#(
  parameter int MY_ROW = 0,
  parameter int MY_COL = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PID_W-1:0]  in_id,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PID_W-1:0]  out_id,
  output logic [DATA_W-1:0] out_data,
  output logic [DIR_W-1:0]  out_dir
);

  localparam logic [POS_W-1:0]   ROW_ID = POS_W'(MY_ROW);
  localparam logic [POS_W-1:0]   COL_ID = POS_W'(MY_COL);
  localparam logic [2*POS_W-1:0] SELF   = {ROW_ID, COL_ID};

  // Decode of the accepted packet
  logic                  accept;
  logic                  is_setact;
  logic                  is_setreg;
  logic                  is_resv;
  logic [2*POS_W-1:0]    tgt;
  logic                  hit;

  assign accept    = in_valid && in_ready;
  assign is_setact = (in_id == PID_SETACT);
  assign is_setreg = (in_id == PID_SETREG);
  assign is_resv   = is_setact || is_setreg;
  assign tgt       = in_data[TGT_HI:TGT_LO];
  assign hit       = (tgt == SELF);

  // Action table
  pe_action_t act;
  logic       tbl_we;

  assign tbl_we = accept && is_setact && hit;

  pe_action_table #(.DEPTH(NACTS)) u_tbl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (tbl_we),
    .wr_idx (in_data[SLOT_HI:SLOT_LO]),
    .wr_act (pe_action_t'(in_data[ACT_W-1:0])),
    .rd_idx (in_id),
    .rd_act (act)
  );

  // Register file and operands
  logic              rf_we;
  logic [RIDX_W-1:0] rf_widx;
  logic [DATA_W-1:0] rf_wval;
  logic [DATA_W-1:0] rf_rval;
  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] alu_res;

  pe_regfile #(.DW(DATA_W), .DEPTH(NREGS)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (rf_we),
    .wr_idx (rf_widx),
    .wr_val (rf_wval),
    .rd_idx (act.src),
    .rd_val (rf_rval)
  );

  assign opb = act.src_is_imm ? DATA_W'(act.src) : rf_rval;

  pe_alu #(.DW(DATA_W)) u_alu (
    .fn  (act.fn),
    .opa (in_data),
    .opb (opb),
    .res (alu_res)
  );

  always_comb begin
    rf_we   = 1'b0;
    rf_widx = act.rd;
    rf_wval = alu_res;
    if (accept) begin
      if (is_setreg) begin
        if (hit) begin
          rf_we   = 1'b1;
          rf_widx = in_data[CREG_HI:CREG_LO];
          rf_wval = DATA_W'(in_data[CVAL_W-1:0]);
        end
      end else if (!is_setact) begin
        if (act.val_we) begin
          rf_we   = 1'b1;
          rf_wval = in_data;
        end else if (act.res_we) begin
          rf_we   = 1'b1;
        end
      end
    end
  end

  // Output selection
  logic              ld;
  logic [PID_W-1:0]  ld_id;
  logic [DATA_W-1:0] ld_data;
  logic [DIR_W-1:0]  ld_dir;

  always_comb begin
    ld      = 1'b0;
    ld_id   = act.resp_id;
    ld_data = alu_res;
    ld_dir  = act.dest[DIR_W-1:0];
    if (accept) begin
      if (is_resv) begin
        if (!hit) begin
          ld      = 1'b1;
          ld_id   = in_id;
          ld_data = in_data;
          ld_dir  = (tgt[POS_W-1:0] != COL_ID) ? DIR_EAST : DIR_SOUTH;
        end
      end else if (act.dest < DEST_SINK) begin
        ld = 1'b1;
      end
    end
  end

  pe_out_stage #(.DW(DATA_W), .IDW(PID_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ld),
    .ld_id     (ld_id),
    .ld_data   (ld_data),
    .ld_dir    (ld_dir),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_id    (out_id),
    .out_data  (out_data),
    .out_dir   (out_dir)
  );

  assign in_ready = !out_valid || out_ready;

endmodule

// File: rtl/pe_checks.sv
module pe_checks
  import pe_pkg::*;
#(
  parameter int MY_ROW = 0,
  parameter int MY_COL = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [PID_W-1:0]  in_id,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PID_W-1:0]  out_id,
  input logic [DATA_W-1:0] out_data,
  input logic [DIR_W-1:0]  out_dir
);

  localparam logic [2*POS_W-1:0] SELF = {POS_W'(MY_ROW), POS_W'(MY_COL)};

  logic resv_in;
  logic resv_foreign;
  logic resv_own;

  assign resv_in      = in_valid && in_ready && (in_id <= PID_SETREG);
  assign resv_foreign = resv_in && (in_data[TGT_HI:TGT_LO] != SELF);
  assign resv_own     = resv_in && (in_data[TGT_HI:TGT_LO] == SELF);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_id) && $stable(out_data) && $stable(out_dir)); // R1

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R1

  AST_OWN_PROG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    resv_own |=> !out_valid); // R3

  AST_FWD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    resv_foreign |=> out_valid && out_id == $past(in_id) && out_data == $past(in_data)); // R5

  AST_FWD_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    resv_foreign |=> out_dir == (($past(in_data[TGT_LO+POS_W-1:TGT_LO]) != POS_W'(MY_COL)) ? DIR_EAST : DIR_SOUTH)); // R5

  AST_IDLE_NO_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && (!out_valid || out_ready) |=> !out_valid); // R11

endmodule

bind pkt_pe pe_checks #(.MY_ROW(MY_ROW), .MY_COL(MY_COL)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_id     (in_id),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_id    (out_id),
  .out_data  (out_data),
  .out_dir   (out_dir)
);

// File: tb/sim_pkt_pe.sv
`timescale 1ns/1ps
module sim_pkt_pe;

  localparam int ROW = 1;
  localparam int COL = 2;
  localparam logic [3:0] ME = 4'b0110;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [3:0]  in_id;
  logic [31:0] in_data;
  logic        out_valid;
  logic        out_ready;
  logic [3:0]  out_id;
  logic [31:0] out_data;
  logic [1:0]  out_dir;

  pkt_pe #(.MY_ROW(ROW), .MY_COL(COL)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_id(in_id), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_id(out_id),
    .out_data(out_data), .out_dir(out_dir)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int   nvec = 0;
  int   nbad = 0;
  bit   done = 0;

  logic        gv;
  logic [3:0]  gid;
  logic [31:0] gdat;
  logic [1:0]  gdir;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic xact(input logic [3:0] id, input logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_id    = id;
    in_data  = d;
    @(posedge clk);
    #1;
    gv   = out_valid;
    gid  = out_id;
    gdat = out_data;
    gdir = out_dir;
    in_valid = 1'b0;
  endtask

  function automatic logic [22:0] mk(input logic [3:0] resp, input logic [2:0] dest,
                                     input logic [4:0] src, input logic [4:0] rd,
                                     input logic rw, input logic vw, input logic si,
                                     input logic [2:0] fn);
    return {resp, dest, src, rd, rw, vw, si, fn};
  endfunction

  task automatic prog(input logic [3:0] slot, input logic [22:0] e);
    xact(4'd0, {1'b0, ME, slot, e});
  endtask

  task automatic ldc(input logic [4:0] r, input logic [15:0] c);
    xact(4'd1, {1'b0, ME, 6'd0, r, c});
  endtask

  task automatic rdreg(input logic [4:0] r, output logic [31:0] v);
    prog(4'd2, mk(4'd9, 3'd1, r, 5'd0, 1'b0, 1'b0, 1'b0, 3'd5));
    xact(4'd2, 32'h0);
    v = gv ? gdat : 32'hxxxxxxxx;
  endtask

  function automatic logic [31:0] pat(input int i);
    case (i)
      0: return 32'h00000000;
      1: return 32'hFFFFFFFF;
      2: return 32'h80000000;
      3: return 32'h00000001;
      4: return 32'h0000001F;
      5: return 32'h00000023;
      6: return 32'h7FFF0104;
      default: return 32'hDEADBEEF;
    endcase
  endfunction

  function automatic logic [31:0] ref_fn(input int f, input logic [31:0] a, input logic [31:0] b);
    int s;
    logic [31:0] fill;
    s = int'(b % 32);
    case (f)
      0: return a + b;
      1: return a * (32'd1 << s);
      2: begin
        fill = a[31] ? ~(32'hFFFFFFFF >> s) : 32'h0;
        return (a >> s) | fill;
      end
      3: return a + (~b + 32'd1);
      4: return (a | b) & ~(a & b);
      5: return b;
      6: return a | b;
      default: return a & b;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nvec++;
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] exp;
    logic [15:0] c;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_id = '0;
    in_data = '0;
    out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!out_valid && in_ready, "R2", "output idle after reset", {62'd0, out_valid, in_ready}, 64'd1);

    // R2: all action slots start as silent sinks
    for (int id = 2; id < 16; id++) begin
      xact(4'(id), 32'h0000_1000 + 32'(id));
      check(!gv, "R2", "reset slot emits nothing", 64'(gv), 64'd0);
    end
    // R2: registers start at zero
    for (int r = 0; r < 32; r++) begin
      rdreg(5'(r), v);
      check(v == 32'h0, "R2", "register zero after reset", 64'(v), 64'd0);
    end

    // R4: constant load into every register
    for (int r = 0; r < 32; r++) begin
      c = 16'h1234 + 16'(r) * 16'h0101;
      ldc(5'(r), c);
      check(!gv, "R4", "constant load silent", 64'(gv), 64'd0);
      rdreg(5'(r), v);
      check(v == {16'h0, c}, "R4", "constant readback", 64'(v), 64'({16'h0, c}));
    end

    // R5 / R3: foreign targets are forwarded unchanged and alter nothing
    for (int t = 0; t < 16; t++) begin
      if (4'(t) != ME) begin
        logic [31:0] d0, d1;
        logic [1:0]  edir;
        edir = (2'(t) != 2'(COL)) ? 2'd1 : 2'd2;
        d0 = {1'b0, 4'(t), 4'd6, mk(4'h7, 3'd1, 5'd0, 5'd0, 1'b0, 1'b0, 1'b1, 3'd0)};
        xact(4'd0, d0);
        check(gv && gid == 4'd0 && gdat == d0 && gdir == edir, "R5", "forward action write",
              {gid, gdir, gdat}, {4'd0, edir, d0});
        d1 = {1'b0, 4'(t), 6'd0, 5'd7, 16'h5555};
        xact(4'd1, d1);
        check(gv && gid == 4'd1 && gdat == d1 && gdir == edir, "R5", "forward constant load",
              {gid, gdir, gdat}, {4'd1, edir, d1});
      end
    end
    xact(4'd6, 32'h1234);
    check(!gv, "R3", "foreign action write ignored", 64'(gv), 64'd0);
    rdreg(5'd7, v);
    exp = {16'h0, 16'h1234 + 16'd7 * 16'h0101};
    check(v == exp, "R5", "foreign constant load ignored", 64'(v), 64'(exp));

    // R3 / R6: own action write with every field distinct
    ldc(5'd3, 16'h0040);
    prog(4'd11, mk(4'hD, 3'd2, 5'd3, 5'd12, 1'b1, 1'b0, 1'b0, 3'd3));
    check(!gv, "R3", "own action write silent", 64'(gv), 64'd0);
    xact(4'd11, 32'h0000_1000);
    check(gv && gid == 4'hD && gdir == 2'd2 && gdat == 32'h0FC0, "R6", "field layout result",
          {gid, gdir, gdat}, {4'hD, 2'd2, 32'h0FC0});
    rdreg(5'd12, v);
    check(v == 32'h0FC0, "R6", "field layout write-back", 64'(v), 64'h0FC0);

    // R7: function sweep; slot 4 loads r5 from the packet value
    prog(4'd4, mk(4'h0, 3'd4, 5'd0, 5'd5, 1'b0, 1'b1, 1'b0, 3'd0));
    for (int f = 0; f < 8; f++) begin
      prog(4'd3, mk(4'hA, 3'd1, 5'd5, 5'd0, 1'b0, 1'b0, 1'b0, 3'(f)));
      for (int bi = 0; bi < 8; bi++) begin
        xact(4'd4, pat(bi));
        for (int ai = 0; ai < 8; ai++) begin
          logic [31:0] a;
          a = pat(ai) ^ (32'(ai) * 32'h01010101);
          exp = ref_fn(f, a, pat(bi));
          xact(4'd3, a);
          check(gv && gid == 4'hA && gdir == 2'd1 && gdat == exp, "R7", "function result",
                {gid, gdir, gdat}, {4'hA, 2'd1, exp});
        end
      end
    end

    // R8: source-is-immediate operand
    for (int k = 0; k < 32; k++) begin
      prog(4'd3, mk(4'hA, 3'd1, 5'(k), 5'd0, 1'b0, 1'b0, 1'b1, 3'd0));
      xact(4'd3, 32'h1000_0000);
      exp = 32'h1000_0000 + 32'(k);
      check(gv && gdat == exp, "R8", "immediate operand", 64'(gdat), 64'(exp));
    end

    // R9: write selection and precedence
    xact(4'd4, 32'h0000_0100);
    prog(4'd5, mk(4'h0, 3'd4, 5'd5, 5'd8, 1'b1, 1'b0, 1'b0, 3'd0));
    xact(4'd5, 32'h11);
    rdreg(5'd8, v);
    check(v == 32'h111, "R9", "result write", 64'(v), 64'h111);
    prog(4'd5, mk(4'h0, 3'd4, 5'd5, 5'd8, 1'b1, 1'b1, 1'b0, 3'd0));
    xact(4'd5, 32'hABCD1234);
    rdreg(5'd8, v);
    check(v == 32'hABCD1234, "R9", "value write wins", 64'(v), 64'hABCD1234);

    // R10: every destination code
    for (int d = 0; d < 8; d++) begin
      logic [31:0] dv;
      dv = 32'hC0DE0000 | 32'(d);
      prog(4'd5, mk(4'h3, 3'(d), 5'd0, 5'd10, 1'b1, 1'b0, 1'b1, 3'd0));
      xact(4'd5, dv);
      if (d < 4)
        check(gv && gid == 4'h3 && gdir == 2'(d) && gdat == dv, "R10", "emitting destination",
              {gv, gid, gdir, gdat}, {1'b1, 4'h3, 2'(d), dv});
      else
        check(!gv, "R10", "sink destination silent", 64'(gv), 64'd0);
      rdreg(5'd10, v);
      check(v == dv, "R10", "side effect on every destination", 64'(v), 64'(dv));
    end

    // R1: stall and release
    prog(4'd3, mk(4'hA, 3'd1, 5'd0, 5'd0, 1'b0, 1'b0, 1'b1, 3'd0));
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_id     = 4'd3;
    in_data   = 32'h111;
    @(posedge clk);
    #1;
    check(out_valid && out_data == 32'h111, "R1", "first result", 64'(out_data), 64'h111);
    check(!in_ready, "R1", "input blocked", 64'(in_ready), 64'd0);
    @(negedge clk);
    in_data = 32'h222;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      #1;
      check(out_valid && out_data == 32'h111 && !in_ready, "R1", "held while stalled",
            {out_valid, in_ready, out_data}, {1'b1, 1'b0, 32'h111});
    end
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk);
    #1;
    check(out_valid && out_data == 32'h222, "R1", "second accepted on release", 64'(out_data), 64'h222);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    #1;
    check(!out_valid, "R1", "drained", 64'(out_valid), 64'd0);

    // R11: idle cycles with live-looking inputs
    @(negedge clk);
    in_valid = 1'b0;
    in_id    = 4'd1;
    in_data  = {1'b0, ME, 6'd0, 5'd9, 16'hBEEF};
    for (int i = 0; i < 5; i++) begin
      @(posedge clk);
      #1;
      check(!out_valid, "R11", "no output when idle", 64'(out_valid), 64'd0);
    end
    rdreg(5'd9, v);
    exp = {16'h0, 16'h1234 + 16'd9 * 16'h0101};
    check(v == exp, "R11", "register untouched when idle", 64'(v), 64'(exp));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule